// File: doc/BRIEF.md
# Coded Parallel Update Transmitter

This block writes parameter updates onto a 16-bit parallel bus that a display controller samples on every clock with no handshake of its own. Each update word pairs a 6-bit code, in the upper bits, with a 10-bit value, in the lower bits. A code whose top bit is set marks the word as valid. The all-zero code means that no update is present.

A word is never written in one step. The block first clears the code field, then places the low eight value bits, and only then drives the code together with the two upper value bits. A receiver that samples at any moment therefore sees either no code at all or a valid code with its complete value. Each phase lasts a programmable number of clocks, and the last word stays on the bus while the block is idle.

A client either asks for one word, giving a code and a value, or asks for a score resynchronisation. A resynchronisation replays the fixed geometry words, built from parameters, and then the score word, all as one burst. The client watches the busy level and a one-cycle done pulse.

Top module: `updtx_top`

## Requirements
- R1: Bus bits [15:10] carry the code and bits [9:0] the value. A single-word request sends the requested code and value unchanged.
- R2: In the first phase of every word, bus bits [15:8] are zero and bits [7:0] keep the low byte that was on the bus before.
- R3: In the second phase, the bus carries zeros in bits [15:8] and value bits [7:0] in bits [7:0].
- R4: In the third phase, the bus carries the code in [15:10] and the full value in [9:0]. This word stays on the bus, unchanged, until the next accepted request.
- R5: Each phase lasts holdLen clocks, sampled when the request is accepted. A holdLen of 0 counts as 1.
- R6: Busy is high from the clock after acceptance until the last phase ends. Done is high for exactly one clock, in the first clock with busy low.
- R7: A single-word request or a score request that arrives while busy has no effect on the bus or on the sequence in progress.
- R8: A score request sends seven words in one burst, with one done pulse at the end. In order: 111000 with 0, 111001 with 635, 110010 with 5, 110011 with 100, 101010 with 16, 101011 with 16, and finally 100100 with the score value.
- R9: When a score request and a single-word request arrive in the same idle cycle, the score burst runs and the single word is discarded.
- R10: A synchronous reset drives the bus to all zeros, clears busy and done, and leaves the block idle, including when reset arrives in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request to send one word |
| reqCode | input | 6 | Code of the single word |
| reqValue | input | 10 | Value of the single word |
| scoreReq | input | 1 | Request to send the geometry-and-score burst |
| scoreValue | input | 10 | Score value for the last word of the burst |
| holdLen | input | 4 | Clocks per phase (0 counts as 1) |
| busy | output | 1 | A word or burst is in progress |
| done | output | 1 | One-cycle completion pulse |
| busOut | output | 16 | Code and value bus to the receiver |

## Verification
The score request and the single-word request can be asserted in the same idle cycle. The bench raises both on one clock edge. It then follows all seven burst words phase by phase, and after the burst it confirms that the bus holds the score word and that no trace of the single code ever appears. The second collision is a new request that lands during an active word. The bench pulses both request inputs in the middle of the second phase and checks that every remaining phase, the done pulse and the idle bus are exactly those of the word already underway.

// File: rtl/updtx_pkg.sv
`timescale 1ns/1ps
package updtx_pkg;
  localparam int BURST_WORDS = 7;
  localparam int IDX_W = 3;

  localparam logic [5:0] C_P1X = 6'b111000;
  localparam logic [5:0] C_P2X = 6'b111001;
  localparam logic [5:0] C_PW  = 6'b110010;
  localparam logic [5:0] C_PH  = 6'b110011;
  localparam logic [5:0] C_BW  = 6'b101010;
  localparam logic [5:0] C_BH  = 6'b101011;
  localparam logic [5:0] C_SC  = 6'b100100;

  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_LOW, S_FULL} phase_t;

  typedef struct packed {
    logic             latchReq;
    logic             latchScore;
    logic             burstSel;
    logic [IDX_W-1:0] wordIdx;
    logic             drvClear;
    logic             drvLow;
    logic             drvFull;
  } strobe_t;

  function automatic logic [5:0] burstCode(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    burstCode = C_P1X;
      3'd1:    burstCode = C_P2X;
      3'd2:    burstCode = C_PW;
      3'd3:    burstCode = C_PH;
      3'd4:    burstCode = C_BW;
      3'd5:    burstCode = C_BH;
      default: burstCode = C_SC;
    endcase
  endfunction
endpackage

// File: rtl/updtx_ctrl.sv
`timescale 1ns/1ps
module updtx_ctrl
  import updtx_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              scoreReq,
  input  logic [HOLD_W-1:0] holdLen,
  output strobe_t           st,
  output logic              busy,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_WORDS - 1);

  phase_t            state;
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] lenReg;
  logic [IDX_W-1:0]  idx;
  logic              burst;
  logic              doneR;

  logic [HOLD_W-1:0] lenEff;
  logic              accept;
  logic              adv;
  logic              more;

  assign lenEff = (holdLen == '0) ? HOLD_W'(1) : holdLen;
  assign accept = (state == S_IDLE) && (reqValid || scoreReq);
  assign adv    = (state != S_IDLE) && (cnt >= lenReg);
  assign more   = burst && (idx != LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      lenReg <= HOLD_W'(1);
      idx    <= '0;
      burst  <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (state == S_IDLE) begin
        if (accept) begin
          state  <= S_CLEAR;
          burst  <= scoreReq;
          idx    <= '0;
          lenReg <= lenEff;
          cnt    <= HOLD_W'(1);
        end
      end else if (adv) begin
        cnt <= HOLD_W'(1);
        case (state)
          S_CLEAR: state <= S_LOW;
          S_LOW:   state <= S_FULL;
          default: begin
            if (more) begin
              idx   <= idx + 1'b1;
              state <= S_CLEAR;
            end else begin
              state <= S_IDLE;
              doneR <= 1'b1;
            end
          end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    st            = '0;
    st.latchReq   = accept && !scoreReq;
    st.latchScore = accept && scoreReq;
    st.burstSel   = burst;
    st.wordIdx    = idx;
    st.drvClear   = accept || (adv && (state == S_FULL) && more);
    st.drvLow     = adv && (state == S_CLEAR);
    st.drvFull    = adv && (state == S_LOW);
  end

  assign busy = (state != S_IDLE);
  assign done = doneR;
endmodule

// File: rtl/updtx_dp.sv
`timescale 1ns/1ps
module updtx_dp
  import updtx_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int VAL_W  = 10,
  parameter int LOW_W  = 8,
  parameter int P1X    = 0,
  parameter int P2X    = 635,
  parameter int PADW   = 5,
  parameter int PADH   = 100,
  parameter int BALLW  = 16,
  parameter int BALLH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 st,
  input  logic [CODE_W-1:0]       reqCode,
  input  logic [VAL_W-1:0]        reqValue,
  input  logic [VAL_W-1:0]        scoreValue,
  output logic [CODE_W+VAL_W-1:0] busOut
);
  localparam int BUS_W = CODE_W + VAL_W;
  localparam int HI_W  = BUS_W - LOW_W;

  logic [CODE_W-1:0] oneCode;
  logic [VAL_W-1:0]  oneVal;
  logic [VAL_W-1:0]  scoreReg;
  logic [CODE_W-1:0] selCode;
  logic [VAL_W-1:0]  selVal;
  logic [BUS_W-1:0]  busReg;

  always_comb begin
    if (st.burstSel) begin
      selCode = CODE_W'(burstCode(st.wordIdx));
      case (st.wordIdx)
        3'd0:    selVal = VAL_W'(P1X);
        3'd1:    selVal = VAL_W'(P2X);
        3'd2:    selVal = VAL_W'(PADW);
        3'd3:    selVal = VAL_W'(PADH);
        3'd4:    selVal = VAL_W'(BALLW);
        3'd5:    selVal = VAL_W'(BALLH);
        default: selVal = scoreReg;
      endcase
    end else begin
      selCode = oneCode;
      selVal  = oneVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oneCode  <= '0;
      oneVal   <= '0;
      scoreReg <= '0;
      busReg   <= '0;
    end else begin
      if (st.latchReq) begin
        oneCode <= reqCode;
        oneVal  <= reqValue;
      end
      if (st.latchScore) scoreReg <= scoreValue;
      if (st.drvClear)     busReg <= {{HI_W{1'b0}}, busReg[LOW_W-1:0]};
      else if (st.drvLow)  busReg <= {{HI_W{1'b0}}, selVal[LOW_W-1:0]};
      else if (st.drvFull) busReg <= {selCode, selVal};
    end
  end

  assign busOut = busReg;
endmodule

// File: rtl/updtx_top.sv
`timescale 1ns/1ps
module updtx_top
  import updtx_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int VAL_W  = 10,
  parameter int HOLD_W = 4,
  parameter int P1X    = 0,
  parameter int P2X    = 635,
  parameter int PADW   = 5,
  parameter int PADH   = 100,
  parameter int BALLW  = 16,
  parameter int BALLH  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [CODE_W-1:0]       reqCode,
  input  logic [VAL_W-1:0]        reqValue,
  input  logic                    scoreReq,
  input  logic [VAL_W-1:0]        scoreValue,
  input  logic [HOLD_W-1:0]       holdLen,
  output logic                    busy,
  output logic                    done,
  output logic [CODE_W+VAL_W-1:0] busOut
);
  strobe_t st;

  updtx_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .scoreReq(scoreReq),
    .holdLen(holdLen), .st(st), .busy(busy), .done(done)
  );

  updtx_dp #(
    .CODE_W(CODE_W), .VAL_W(VAL_W), .LOW_W(8), .P1X(P1X), .P2X(P2X),
    .PADW(PADW), .PADH(PADH), .BALLW(BALLW), .BALLH(BALLH)
  ) u_dp (
    .clk(clk), .rst(rst), .st(st), .reqCode(reqCode), .reqValue(reqValue),
    .scoreValue(scoreValue), .busOut(busOut)
  );
endmodule

// File: rtl/updtx_chk.sv
`timescale 1ns/1ps
module updtx_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [BUS_W-1:0] busOut
);
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !busy));

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r3_low_before_code: assert property (@(posedge clk) disable iff (rst)
    $rose(busOut[BUS_W-1]) |->
      (($past(busOut[BUS_W-1:8]) == '0) && $stable(busOut[7:0])));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(busOut));

  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> ((busOut == '0) && !busy && !done));
endmodule

bind updtx_top updtx_chk #(.BUS_W(CODE_W + VAL_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .busOut(busOut)
);

// File: tb/sim_updtx_top.sv
`timescale 1ns/1ps
module sim_updtx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [5:0]  reqCode = '0;
  logic [9:0]  reqValue = '0;
  logic        scoreReq = 1'b0;
  logic [9:0]  scoreValue = '0;
  logic [3:0]  holdLen = 4'd1;
  logic        busy;
  logic        done;
  logic [15:0] busOut;

  int vecs = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] lastLow = 8'h00;

  always #10 clk = ~clk;

  updtx_top u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCode(reqCode),
    .reqValue(reqValue), .scoreReq(scoreReq), .scoreValue(scoreValue),
    .holdLen(holdLen), .busy(busy), .done(done), .busOut(busOut)
  );

  // {holdLen[3:0], code[5:0], value[9:0]}
  localparam logic [19:0] VECS [6] = '{
    {4'd1, 6'b110000, 10'h2AB},
    {4'd2, 6'b110001, 10'h155},
    {4'd3, 6'b101000, 10'h3FF},
    {4'd0, 6'b101001, 10'h000},
    {4'd1, 6'b110010, 10'h080},
    {4'd4, 6'b110011, 10'h301}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input bit one, input bit sc, input logic [5:0] c,
                        input logic [9:0] v, input logic [9:0] s,
                        input logic [3:0] n);
    @(negedge clk);
    reqValid = one; reqCode = c; reqValue = v;
    scoreReq = sc; scoreValue = s; holdLen = n;
    @(posedge clk);
    #2;
    reqValid = 1'b0; scoreReq = 1'b0;
  endtask

  // Follows one word from the first negedge after its first phase begins.
  task automatic followWord(input logic [5:0] c, input logic [9:0] v,
                            input logic [3:0] n, input bit poke);
    int len;
    logic [15:0] exp;
    len = (n == 0) ? 1 : int'(n);
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (poke) begin
          reqValid = 1'b0; scoreReq = 1'b0;
        end
        case (p)
          0: exp = {8'h00, lastLow};
          1: exp = {8'h00, v[7:0]};
          default: exp = {c, v};
        endcase
        if (p == 0) chk(busOut == exp, "R2", 32'(busOut), 32'(exp));
        else if (p == 1) chk(busOut == exp, "R3", 32'(busOut), 32'(exp));
        else chk(busOut == exp, "R4", 32'(busOut), 32'(exp));
        chk(busy === 1'b1 && done === 1'b0, "R6/R5 busy in phase",
            32'({busy, done}), 32'h2);
        if (poke && p == 1 && k == 0) begin
          reqValid = 1'b1; reqCode = 6'b100100; reqValue = 10'h0F0;
          scoreReq = 1'b1; scoreValue = 10'h011;
        end
      end
    end
    lastLow = v[7:0];
  endtask

  task automatic finishWord(input logic [5:0] c, input logic [9:0] v);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R6 done pulse", 32'({busy, done}), 32'h1);
    chk(busOut == {c, v}, "R4 hold at done", 32'(busOut), 32'({c, v}));
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", 32'(done), 32'h0);
    chk(busOut == {c, v}, "R4 hold idle", 32'(busOut), 32'({c, v}));
  endtask

  initial begin
    logic [5:0] bc [7];
    logic [9:0] bv [7];
    bc = '{6'b111000, 6'b111001, 6'b110010, 6'b110011, 6'b101010, 6'b101011, 6'b100100};
    bv = '{10'd0, 10'd635, 10'd5, 10'd100, 10'd16, 10'd16, 10'h0A3};

    // R10: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busOut == 16'h0 && !busy && !done, "R10 reset state",
        32'({busOut, busy, done}), 32'h0);

    // Table walk: single words, R1 R2 R3 R4 R5 R6
    foreach (VECS[i]) begin
      launch(1'b1, 1'b0, VECS[i][15:10], VECS[i][9:0], 10'h0, VECS[i][19:16]);
      followWord(VECS[i][15:10], VECS[i][9:0], VECS[i][19:16], 1'b0);
      finishWord(VECS[i][15:10], VECS[i][9:0]);
      chk(busOut[15:10] == VECS[i][15:10], "R1 code field",
          32'(busOut[15:10]), 32'(VECS[i][15:10]));
    end

    // R7: requests during busy are ignored
    launch(1'b1, 1'b0, 6'b111001, 10'h2C4, 10'h0, 4'd2);
    followWord(6'b111001, 10'h2C4, 4'd2, 1'b1);
    finishWord(6'b111001, 10'h2C4);
    repeat (3) @(negedge clk);
    chk(!busy && busOut == {6'b111001, 10'h2C4}, "R7 no late start",
        32'({busy, busOut}), 32'({6'b111001, 10'h2C4}));

    // R8 + R9: score burst and single word in the same idle cycle
    launch(1'b1, 1'b1, 6'b101000, 10'h1E1, 10'h0A3, 4'd2);
    for (int w = 0; w < 7; w++) followWord(bc[w], bv[w], 4'd2, 1'b0);
    finishWord(6'b100100, 10'h0A3);
    repeat (4) @(negedge clk);
    chk(!busy && busOut == {6'b100100, 10'h0A3}, "R9 single word dropped",
        32'({busy, busOut}), 32'({6'b100100, 10'h0A3}));

    // R8: burst with one-clock phases
    launch(1'b0, 1'b1, 6'h0, 10'h0, 10'h3C5, 4'd1);
    bv[6] = 10'h3C5;
    for (int w = 0; w < 7; w++) followWord(bc[w], bv[w], 4'd1, 1'b0);
    finishWord(6'b100100, 10'h3C5);

    // R10: reset in the middle of a word
    launch(1'b1, 1'b0, 6'b110000, 10'h3AA, 10'h0, 4'd3);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busOut == 16'h0 && !busy && !done, "R10 reset mid word",
        32'({busOut, busy, done}), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs + 1, fails + 1);
      $finish;
    end
  end
endmodule